// File: doc/BRIEF.md
# Serial Channel Control Register File

This block is the software-facing register file of a simple asynchronous serial channel. It sits on a byte-wide register bus with a 64-byte window. It keeps two mode bytes, a transmit holding byte, an interrupt mask, a sticky break flag, and the enable state of each direction. It turns a packed command byte into reset, enable and disable actions. It raises one level-sensitive interrupt.

The block does no serialization of its own. When a transmit byte is ready, it hands the byte to an external shifter as a one-cycle strobe. It observes an external receive queue through two flags and a head byte. It pops that queue when software reads the receive data offset, and flushes it when the receiver is reset. Both divisor bytes are fixed by parameters and can only be read.

Bus reads are combinational. All state changes at the clock edge that ends the access.

Top module: `ucr_regif`

## Requirements
- R1: After synchronous reset, both mode bytes read 0x00, the interrupt status and mask are 0x00, `irq` is low, both directions are disabled, and the status byte reads 0x08 while the queue flags are low.
- R2: Both mode bytes sit at offset 0x00 behind a pointer that starts at the first byte. A write to 0x00 stores into the byte the pointer selects and then moves the pointer to the second byte. A read of 0x00 returns the selected byte. A command whose bits [6:4] equal 1 moves the pointer back to the first byte.
- R3: The status byte at offset 0x04 has this layout:
  - bit0 is the queue-nonempty flag.
  - bit1 is the queue-full flag.
  - bit2 is transmit-ready.
  - bit3 is transmit-empty.
  - bits [7:4] read 0.
- R4: If the transmitter is enabled, a write to offset 0x0C raises `tx_valid` with the written byte for exactly the cycle after the write edge. Transmit-empty stays 1 and transmit-ready stays 1.
- R5: If the transmitter is disabled, a write to offset 0x0C holds the byte without a strobe and clears transmit-empty and transmit-ready. A later transmit enable sends the held byte and sets transmit-empty again.
- R6: Command bits [3:2] control the transmitter: 1 enables it, 2 disables it, and 3 does nothing. Either 1 or 2 makes transmit-ready equal to the new enable. Command bits [6:4] equal to 3 disable the transmitter, set transmit-empty and clear transmit-ready, which drops any held byte. This reset is applied before the bits [3:2] field.
- R7: Command bits [1:0] control the receiver: 1 enables it, 2 disables it, and 3 does nothing. Command bits [6:4] equal to 2 disable the receiver and pulse `rxq_flush` during the write. This reset is applied before the bits [1:0] field, so command 0x21 leaves the receiver enabled.
- R8: A read of offset 0x0C with a nonempty queue returns `rxq_head` and pulses `rxq_pop` in that cycle. With an empty queue it returns 0x00 and does not pop.
- R9: The interrupt status at offset 0x14 has this layout:
  - bit0 follows transmit-ready.
  - bit1 follows queue-full when mode byte 1 bit6 is 1, and queue-nonempty otherwise.
  - bit2 is a sticky break flag. `break_evt` sets it and command bits [6:4] equal to 5 clear it. A set in the same cycle as a clear wins.
  - bits [7:3] read 0.
- R10: A write to offset 0x14 loads the interrupt mask. `irq` is high exactly when the interrupt status AND the mask is nonzero.
- R11: Offsets 0x18 and 0x1C read the parameters `DIV_HI` and `DIV_LO`. Offset 0x10 and every offset not listed above read 0x00. Writes to 0x04, 0x10, 0x18, 0x1C and unlisted offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| tx_valid | output | 1 | One-cycle handoff strobe to the shifter |
| tx_data | output | 8 | Byte handed off with `tx_valid` |
| rxq_nonempty | input | 1 | Receive queue holds at least one byte |
| rxq_full | input | 1 | Receive queue is full |
| rxq_head | input | 8 | Oldest byte in the receive queue |
| rxq_pop | output | 1 | Remove the head byte from the receive queue |
| rxq_flush | output | 1 | Empty the receive queue |
| rx_enable | output | 1 | Receiver enable toward the queue's producer |
| break_evt | input | 1 | Break detected on the line, one-cycle pulse |
| irq | output | 1 | Level interrupt |

## Verification
Two sources can touch the sticky break flag in the same cycle: a line break arriving on `break_evt` and software clearing the flag with command field value 5. The bench provokes this in the command sweep. It pulses `break_evt` during the same write as every command whose low nibble is 0xB, so some of those writes also carry the clear code. It expects the flag to read 1 afterwards and `irq` to follow whenever mask bit2 is set.

A second overlap occurs within one command byte. A reset action and an enable field can both appear, for example 0x21 or 0x35. The bench sweeps all 256 command bytes against a model that applies the reset first.

// File: rtl/ucr_pkg.sv
package ucr_pkg;

    localparam int BYTE_W = 8;

    // register offsets inside the 64-byte window
    localparam logic [5:0] OFS_MODE  = 6'h00;
    localparam logic [5:0] OFS_STAT  = 6'h04;
    localparam logic [5:0] OFS_CMD   = 6'h08;
    localparam logic [5:0] OFS_DATA  = 6'h0C;
    localparam logic [5:0] OFS_AUX   = 6'h10;
    localparam logic [5:0] OFS_INT   = 6'h14;
    localparam logic [5:0] OFS_DIVH  = 6'h18;
    localparam logic [5:0] OFS_DIVL  = 6'h1C;

    // status byte bit positions
    localparam int ST_RXNE  = 0;
    localparam int ST_RXFUL = 1;
    localparam int ST_TXRDY = 2;
    localparam int ST_TXEMP = 3;

    // interrupt status bit positions
    localparam int IS_TX  = 0;
    localparam int IS_RX  = 1;
    localparam int IS_BRK = 2;

    // mode byte 1 bit choosing the receive interrupt source
    localparam int MODE_RXSRC = 6;

    typedef enum logic [2:0] {
        MISC_NOP     = 3'd0,
        MISC_PTR_RST = 3'd1,
        MISC_RX_RST  = 3'd2,
        MISC_TX_RST  = 3'd3,
        MISC_ERR_RST = 3'd4,
        MISC_BRK_CLR = 3'd5,
        MISC_BRK_ON  = 3'd6,
        MISC_BRK_OFF = 3'd7
    } misc_e;

    typedef enum logic [1:0] {
        DIR_KEEP = 2'd0,
        DIR_ON   = 2'd1,
        DIR_OFF  = 2'd2,
        DIR_RSVD = 2'd3
    } dir_e;

    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic brk_clr;
        dir_e tx_op;
        dir_e rx_op;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_t  c;
        misc_e m;
        m         = misc_e'(b[6:4]);
        c.ptr_rst = (m == MISC_PTR_RST);
        c.rx_rst  = (m == MISC_RX_RST);
        c.tx_rst  = (m == MISC_TX_RST);
        c.brk_clr = (m == MISC_BRK_CLR);
        c.tx_op   = dir_e'(b[3:2]);
        c.rx_op   = dir_e'(b[1:0]);
        return c;
    endfunction

    // new enable after a direction field; reserved and keep hold the value
    function automatic logic dir_apply(input logic cur, input dir_e op);
        case (op)
            DIR_ON:  return 1'b1;
            DIR_OFF: return 1'b0;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/ucr_cmd_decode.sv
module ucr_cmd_decode
    import ucr_pkg::*;
(
    input  logic              cmd_wr,
    input  logic [BYTE_W-1:0] cmd_byte,
    output cmd_t              act
);
    always_comb begin
        if (cmd_wr) begin
            act = decode_cmd(cmd_byte);
        end else begin
            act = '{ptr_rst: 1'b0, rx_rst: 1'b0, tx_rst: 1'b0,
                    brk_clr: 1'b0, tx_op: DIR_KEEP, rx_op: DIR_KEEP};
        end
    end
endmodule

// File: rtl/ucr_mode_regs.sv
module ucr_mode_regs
    import ucr_pkg::*;
#(
    parameter int NUM_MODE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ptr_rst,
    output logic [BYTE_W-1:0] mode_first,
    output logic [BYTE_W-1:0] mode_sel
);
    localparam int PTR_W = (NUM_MODE > 1) ? $clog2(NUM_MODE) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_MODE - 1);

    logic [BYTE_W-1:0] mode_q [NUM_MODE];
    logic [PTR_W-1:0]  ptr_q;

    for (genvar i = 0; i < NUM_MODE; i++) begin : g_mode
        always_ff @(posedge clk) begin
            if (rst) begin
                mode_q[i] <= '0;
            end else if (wr_en && ptr_q == PTR_W'(i)) begin
                mode_q[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ptr_rst) begin
            ptr_q <= '0;
        end else if (wr_en && ptr_q != PTR_LAST) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign mode_first = mode_q[0];
    assign mode_sel   = mode_q[ptr_q];

    // R2
    ptr_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ptr_q == '0) |=> (ptr_q != '0));
endmodule

// File: rtl/ucr_tx_path.sv
module ucr_tx_path
    import ucr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              thr_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tx_rst,
    input  dir_e              tx_op,
    output logic              tx_en,
    output logic              tx_empty,
    output logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);
    logic [BYTE_W-1:0] hold_q, hold_n;
    logic              en_n, emp_n, rdy_n, send, refresh;

    always_comb begin
        en_n    = tx_rst ? 1'b0 : tx_en;
        emp_n   = tx_rst ? 1'b1 : tx_empty;
        rdy_n   = tx_rst ? 1'b0 : tx_ready;
        hold_n  = hold_q;
        refresh = 1'b0;
        send    = 1'b0;
        if (thr_wr) begin
            emp_n   = 1'b0;
            hold_n  = wdata;
            refresh = 1'b1;
        end
        if (tx_op == DIR_ON || tx_op == DIR_OFF) begin
            en_n    = dir_apply(en_n, tx_op);
            refresh = 1'b1;
        end
        if (refresh) begin
            if (en_n && !emp_n) begin
                send  = 1'b1;
                emp_n = 1'b1;
            end
            rdy_n = en_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en    <= 1'b0;
            tx_empty <= 1'b1;
            tx_ready <= 1'b0;
            hold_q   <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_en    <= en_n;
            tx_empty <= emp_n;
            tx_ready <= rdy_n;
            hold_q   <= hold_n;
            tx_valid <= send;
            if (send) begin
                tx_data <= hold_n;
            end
        end
    end

    // R5
    held_no_send_chk: assert property (@(posedge clk) disable iff (rst)
        (thr_wr && !tx_en) |=> (!tx_empty && !tx_valid));
    // R6
    tx_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_rst && tx_op != DIR_ON) |=> (tx_empty && !tx_ready && !tx_en));
endmodule

// File: rtl/ucr_irq_ctrl.sv
module ucr_irq_ctrl
    import ucr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              brk_evt,
    input  logic              brk_clr,
    input  logic              tx_ready,
    input  logic              q_nonempty,
    input  logic              q_full,
    input  logic              rx_on_full,
    output logic [BYTE_W-1:0] int_stat,
    output logic              irq
);
    logic [BYTE_W-1:0] mask_q;
    logic              brk_q;
    logic              rx_src;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            brk_q  <= 1'b0;
        end else begin
            if (mask_wr) begin
                mask_q <= wdata;
            end
            if (brk_evt) begin
                brk_q <= 1'b1;
            end else if (brk_clr) begin
                brk_q <= 1'b0;
            end
        end
    end

    assign rx_src = rx_on_full ? q_full : q_nonempty;

    always_comb begin
        int_stat         = '0;
        int_stat[IS_TX]  = tx_ready;
        int_stat[IS_RX]  = rx_src;
        int_stat[IS_BRK] = brk_q;
    end

    assign irq = |(int_stat & mask_q);

    // R9
    brk_wins_chk: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> int_stat[IS_BRK]);
    // R10
    brk_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_evt && mask_q[IS_BRK] && !mask_wr) |=> irq);
endmodule

// File: rtl/ucr_regif.sv
module ucr_regif
    import ucr_pkg::*;
#(
    parameter int          ADDR_W = 6,
    parameter logic [7:0]  DIV_HI = 8'h00,
    parameter logic [7:0]  DIV_LO = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              rxq_nonempty,
    input  logic              rxq_full,
    input  logic [7:0]        rxq_head,
    output logic              rxq_pop,
    output logic              rxq_flush,
    output logic              rx_enable,
    input  logic              break_evt,
    output logic              irq
);
    function automatic logic at(input logic [ADDR_W-1:0] a, input logic [5:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    logic        mode_wr, cmd_wr, thr_wr, mask_wr, data_rd;
    cmd_t        act;
    logic [7:0]  mode_first, mode_sel, int_stat, status;
    logic        tx_en, tx_empty, tx_ready;
    logic        rx_en_q;

    assign mode_wr = bus_wr && at(bus_addr, OFS_MODE);
    assign cmd_wr  = bus_wr && at(bus_addr, OFS_CMD);
    assign thr_wr  = bus_wr && at(bus_addr, OFS_DATA);
    assign mask_wr = bus_wr && at(bus_addr, OFS_INT);
    assign data_rd = bus_rd && at(bus_addr, OFS_DATA);

    ucr_cmd_decode u_dec (
        .cmd_wr   (cmd_wr),
        .cmd_byte (bus_wdata),
        .act      (act)
    );

    ucr_mode_regs #(.NUM_MODE(2)) u_mode (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (mode_wr),
        .wdata      (bus_wdata),
        .ptr_rst    (act.ptr_rst),
        .mode_first (mode_first),
        .mode_sel   (mode_sel)
    );

    ucr_tx_path u_tx (
        .clk      (clk),
        .rst      (rst),
        .thr_wr   (thr_wr),
        .wdata    (bus_wdata),
        .tx_rst   (act.tx_rst),
        .tx_op    (act.tx_op),
        .tx_en    (tx_en),
        .tx_empty (tx_empty),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    ucr_irq_ctrl u_irq (
        .clk        (clk),
        .rst        (rst),
        .mask_wr    (mask_wr),
        .wdata      (bus_wdata),
        .brk_evt    (break_evt),
        .brk_clr    (act.brk_clr),
        .tx_ready   (tx_ready),
        .q_nonempty (rxq_nonempty),
        .q_full     (rxq_full),
        .rx_on_full (mode_first[MODE_RXSRC]),
        .int_stat   (int_stat),
        .irq        (irq)
    );

    // receiver enable: reset action first, then the direction field
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en_q <= 1'b0;
        end else begin
            rx_en_q <= dir_apply(act.rx_rst ? 1'b0 : rx_en_q, act.rx_op);
        end
    end

    assign rx_enable = rx_en_q;
    assign rxq_flush = act.rx_rst;
    assign rxq_pop   = data_rd && rxq_nonempty;

    always_comb begin
        status           = '0;
        status[ST_RXNE]  = rxq_nonempty;
        status[ST_RXFUL] = rxq_full;
        status[ST_TXRDY] = tx_ready;
        status[ST_TXEMP] = tx_empty;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (at(bus_addr, OFS_MODE))      bus_rdata = mode_sel;
            else if (at(bus_addr, OFS_STAT)) bus_rdata = status;
            else if (at(bus_addr, OFS_DATA)) bus_rdata = rxq_nonempty ? rxq_head : 8'h00;
            else if (at(bus_addr, OFS_INT))  bus_rdata = int_stat;
            else if (at(bus_addr, OFS_DIVH)) bus_rdata = DIV_HI;
            else if (at(bus_addr, OFS_DIVL)) bus_rdata = DIV_LO;
            else if (at(bus_addr, OFS_AUX))  bus_rdata = 8'h00;
        end
    end

    // R4
    tx_source_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(bus_wr));
    // R7
    rx_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (rxq_flush && bus_wdata[1:0] != 2'd1) |=> !rx_enable);
    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !rxq_nonempty) |-> (bus_rdata == 8'h00 && !rxq_pop));
endmodule

// File: tb/ucr_regif_test.sv
module ucr_regif_test;
    localparam logic [7:0] P_HI = 8'h5E;
    localparam logic [7:0] P_LO = 8'hB1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       rq_ne = 1'b0, rq_full = 1'b0;
    logic [7:0] rq_data = '0;
    logic       rxq_pop, rxq_flush, rx_enable, brk = 1'b0, irq;

    int nchk = 0, nfail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ucr_regif #(.ADDR_W(6), .DIV_HI(P_HI), .DIV_LO(P_LO)) uut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .rxq_nonempty(rq_ne), .rxq_full(rq_full), .rxq_head(rq_data),
        .rxq_pop(rxq_pop), .rxq_flush(rxq_flush), .rx_enable(rx_enable),
        .break_evt(brk), .irq(irq)
    );

    // reference model state
    logic [7:0] m_mr [2];
    logic       m_ptr, m_txen, m_txemp, m_txrdy, m_rxen, m_db, m_txv;
    logic [7:0] m_thr, m_imr, m_txd;

    task automatic model_reset();
        m_mr[0] = 0; m_mr[1] = 0; m_ptr = 0; m_txen = 0; m_txemp = 1; m_txrdy = 0;
        m_rxen = 0; m_db = 0; m_txv = 0; m_thr = 0; m_imr = 0; m_txd = 0;
    endtask

    function automatic logic [7:0] m_isr();
        logic rxi = m_mr[0][6] ? rq_full : rq_ne;
        return {5'b0, m_db, rxi, m_txrdy};
    endfunction

    function automatic logic [7:0] m_read(input logic [5:0] a);
        case (a)
            6'h00: return m_mr[m_ptr];
            6'h04: return {4'b0, m_txemp, m_txrdy, rq_full, rq_ne};
            6'h0C: return rq_ne ? rq_data : 8'h00;
            6'h14: return m_isr();
            6'h18: return P_HI;
            6'h1C: return P_LO;
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_dotx();
        if (m_txen && !m_txemp) begin
            m_txv = 1; m_txd = m_thr; m_txemp = 1;
        end
        m_txrdy = m_txen;
    endtask

    task automatic model_write(input logic [5:0] a, input logic [7:0] d);
        case (a)
            6'h00: begin m_mr[m_ptr] = d; m_ptr = 1; end
            6'h08: begin
                case (d[6:4])
                    3'd1: m_ptr = 0;
                    3'd2: m_rxen = 0;
                    3'd3: begin m_txen = 0; m_txemp = 1; m_txrdy = 0; end
                    3'd5: m_db = 0;
                    default: ;
                endcase
                if (d[3:2] == 2'd1) begin m_txen = 1; m_dotx(); end
                else if (d[3:2] == 2'd2) begin m_txen = 0; m_dotx(); end
                if (d[1:0] == 2'd1) m_rxen = 1;
                else if (d[1:0] == 2'd2) m_rxen = 0;
            end
            6'h0C: begin m_txemp = 0; m_thr = d; m_dotx(); end
            6'h14: m_imr = d;
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, sample combinational outputs, then registered ones
    task automatic op(input logic w, input logic r, input logic [5:0] a,
                      input logic [7:0] d, input logic b);
        logic [7:0] exp_rd;
        @(negedge clk);
        wr = w; rd = r; addr = a; wdata = d; brk = b;
        #1;
        if (r) begin
            exp_rd = m_read(a);
            if (a == 6'h00)      chk("R2 mode read", rdata, exp_rd);
            else if (a == 6'h04) chk("R3 status", rdata, exp_rd);
            else if (a == 6'h0C) chk("R8 rx data", rdata, exp_rd);
            else if (a == 6'h14) chk("R9 int status", rdata, exp_rd);
            else                 chk("R11 other read", rdata, exp_rd);
        end
        chk("R8 pop", {7'b0, rxq_pop}, {7'b0, r && a == 6'h0C && rq_ne});
        chk("R7 flush", {7'b0, rxq_flush}, {7'b0, w && a == 6'h08 && d[6:4] == 3'd2});
        @(posedge clk);
        m_txv = 0;
        if (w) model_write(a, d);
        if (w && a == 6'h08 && d[6:4] == 3'd5) m_db = 0;
        if (b) m_db = 1;
        #1;
        chk("R4 tx strobe", {7'b0, tx_valid}, {7'b0, m_txv});
        if (m_txv) chk("R4 tx byte", tx_data, m_txd);
        chk("R7 rx enable", {7'b0, rx_enable}, {7'b0, m_rxen});
        chk("R10 irq", {7'b0, irq}, {7'b0, |(m_isr() & m_imr)});
        wr = 0; rd = 0; brk = 0;
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 64; a++) op(1'b0, 1'b1, 6'(a), 8'h00, 1'b0);
        chk(tag, 8'h00, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1: reset state across the whole window
        chk("R1 irq low", {7'b0, irq}, 8'h00);
        chk("R1 rx off", {7'b0, rx_enable}, 8'h00);
        read_all("R1 sweep");

        // R2: pointer walk
        op(1, 0, 6'h00, 8'hA1, 0);
        op(0, 1, 6'h00, 0, 0);
        op(1, 0, 6'h00, 8'hB2, 0);
        op(1, 0, 6'h00, 8'hC3, 0);
        op(0, 1, 6'h00, 0, 0);
        op(1, 0, 6'h08, 8'h10, 0);
        op(0, 1, 6'h00, 0, 0);
        chk("R2 first byte kept", m_mr[0], 8'hA1);

        // R5 then R4: hold while disabled, enable sends it
        op(1, 0, 6'h0C, 8'h77, 0);
        op(0, 1, 6'h04, 0, 0);
        op(1, 0, 6'h08, 8'h04, 0);
        op(0, 0, 6'h00, 0, 0);
        op(1, 0, 6'h0C, 8'h3D, 0);
        op(0, 1, 6'h04, 0, 0);

        // sweep of all command bytes with varied queue flags, masks and breaks
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cb = 8'(c);
            rq_ne   = cb[0] ^ cb[3];
            rq_full = rq_ne & cb[5];
            rq_data = cb ^ 8'hC3;
            if (cb[1:0] == 2'd0) op(1, 0, 6'h08, 8'h10, 0);
            op(1, 0, 6'h00, ((cb << 1) & 8'h40) | 8'h13, 0);
            op(1, 0, 6'h14, cb ^ 8'h96, 0);
            op(1, 0, 6'h0C, cb ^ 8'h5A, 0);
            op(1, 0, 6'h08, cb, cb[3:0] == 4'hB);   // R9 break and clear may collide
            op(0, 1, 6'h00, 0, 0);
            op(0, 1, 6'h04, 0, 0);
            op(0, 1, 6'h0C, 0, 0);
            op(0, 1, 6'h14, 0, 0);
            op(0, 0, 6'h00, 0, cb[6] & cb[1]);
        end

        // R11: writes to ignored offsets leave every register intact
        rq_ne = 1; rq_full = 0; rq_data = 8'h6C;
        for (int a = 0; a < 64; a++) begin
            if (a != 0 && a != 8 && a != 12 && a != 20) op(1, 0, 6'(a), 8'hFF, 0);
        end
        read_all("R11 sweep");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule